// File: doc/BRIEF.md
# Three-Bit Up/Down Counter with Separate Direction Enables

This block keeps a three-bit count and moves it by one on each rising clock edge. The direction comes from two independent enable lines, one for counting up and one for counting down. When neither line is high, the count stays where it is. The count wraps in both directions. The next value comes from per-bit toggle equations. Each bit flips when counting up and every lower bit is 1, or when counting down and every lower bit is 0.

Raising both enables together is a forbidden request. In that case the count does not move. A fault output goes high in the same cycle that both enables are high, so the surrounding logic can see the conflict. A synchronous reset brings the count back to zero.

Top module: `updn_counter`

## Requirements
- R1: When `rst` is high at a rising edge, `count` is 000 after that edge, whatever the enables are.
- R2: With `upEn`=1 and `downEn`=0, `count` increases by one at each rising edge.
- R3: With `upEn`=0 and `downEn`=1, `count` decreases by one at each rising edge.
- R4: With both enables at 0, `count` keeps its value across the edge.
- R5: With both enables at 1, `count` keeps its value across the edge, and `fault` is 1 during that same cycle. `fault` is a combinational function of the enables.
- R6: Counting up from 111 gives 000.
- R7: Counting down from 000 gives 111.
- R8: `fault` is 0 whenever the two enables are not both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| upEn | input | 1 | Request to count up |
| downEn | input | 1 | Request to count down |
| count | output | 3 | Current count; bit 2 is the most significant |
| fault | output | 1 | High while both enables are high |

## Verification
The hardest case to reach is the forbidden request arriving right after a wrap. It has to be shown that the count freezes at the wrapped value and does not carry on. The stimulus first drives the count up through 111 into 000. It then raises both enables while the count sits at a boundary value, and later repeats this after counting down past zero. A reset is also applied while up-counting is still requested, to show that reset wins over a live enable.

// File: rtl/updn_counter_pkg.sv
package updn_counter_pkg;

  localparam int CNT_W = 3;

  typedef struct packed {
    logic stepUp;
    logic stepDown;
    logic clear;
  } cnt_strobe_t;

endpackage

// File: rtl/updn_counter_ctrl.sv
module updn_counter_ctrl
  import updn_counter_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        upEn,
  input  logic        downEn,
  output cnt_strobe_t strobe,
  output logic        fault
);

  logic conflict;

  always_comb begin
    conflict        = upEn & downEn;
    strobe.clear    = rst;
    strobe.stepUp   = upEn & ~downEn;
    strobe.stepDown = downEn & ~upEn;
    fault           = conflict;
  end

  // R5: a conflicting request never reaches the datapath as a step
  a_r5_no_step_on_fault: assert property (@(posedge clk)
    fault |-> !(strobe.stepUp || strobe.stepDown));

  // R8: fault only when both lines are raised
  a_r8_fault_needs_both: assert property (@(posedge clk)
    fault |-> (upEn && downEn));

  // strobes never both active
  a_r2_r3_exclusive_steps: assert property (@(posedge clk)
    !(strobe.stepUp && strobe.stepDown));

endmodule

// File: rtl/updn_counter_dp.sv
module updn_counter_dp
  import updn_counter_pkg::*;
#(
  parameter int WIDTH = CNT_W
)(
  input  logic             clk,
  input  cnt_strobe_t      strobe,
  output logic [WIDTH-1:0] cnt
);

  localparam logic [WIDTH-1:0] ALL_ONE = {WIDTH{1'b1}};

  logic [WIDTH:0]   lowOnes;
  logic [WIDTH:0]   lowZeros;
  logic [WIDTH-1:0] toggle;
  logic [WIDTH-1:0] cntNext;

  assign lowOnes[0]  = 1'b1;
  assign lowZeros[0] = 1'b1;

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    assign lowOnes[i+1]  = lowOnes[i] & cnt[i];
    assign lowZeros[i+1] = lowZeros[i] & ~cnt[i];
    assign toggle[i]     = (strobe.stepUp & lowOnes[i]) | (strobe.stepDown & lowZeros[i]);
    assign cntNext[i]    = cnt[i] ^ toggle[i];
  end

  always_ff @(posedge clk) begin
    if (strobe.clear) cnt <= '0;
    else              cnt <= cntNext;
  end

  // R1: clear forces zero
  a_r1_clear_zero: assert property (@(posedge clk)
    strobe.clear |=> (cnt == '0));

  // R2: up step adds one
  a_r2_up_step: assert property (@(posedge clk) disable iff (strobe.clear)
    strobe.stepUp |=> (cnt == WIDTH'($past(cnt) + 1'b1)));

  // R3: down step subtracts one
  a_r3_down_step: assert property (@(posedge clk) disable iff (strobe.clear)
    strobe.stepDown |=> (cnt == WIDTH'($past(cnt) - 1'b1)));

  // R4, R5: no step means hold
  a_r4_hold: assert property (@(posedge clk) disable iff (strobe.clear)
    (!strobe.stepUp && !strobe.stepDown) |=> $stable(cnt));

  // R6: up wrap
  a_r6_up_wrap: assert property (@(posedge clk) disable iff (strobe.clear)
    (strobe.stepUp && cnt == ALL_ONE) |=> (cnt == '0));

  // R7: down wrap
  a_r7_down_wrap: assert property (@(posedge clk) disable iff (strobe.clear)
    (strobe.stepDown && cnt == '0) |=> (cnt == ALL_ONE));

endmodule

// File: rtl/updn_counter.sv
module updn_counter
  import updn_counter_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             upEn,
  input  logic             downEn,
  output logic [CNT_W-1:0] count,
  output logic             fault
);

  cnt_strobe_t strobe;

  updn_counter_ctrl ctrl_i (
    .clk    (clk),
    .rst    (rst),
    .upEn   (upEn),
    .downEn (downEn),
    .strobe (strobe),
    .fault  (fault)
  );

  updn_counter_dp #(.WIDTH(CNT_W)) dp_i (
    .clk    (clk),
    .strobe (strobe),
    .cnt    (count)
  );

endmodule

// File: tb/updn_counter_tb_top.sv
module updn_counter_tb_top;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b0;
  logic       upEn = 1'b0;
  logic       downEn = 1'b0;
  logic [2:0] count;
  logic       fault;

  int checks = 0;
  int fails  = 0;
  logic [2:0] model = 3'b000;
  logic [2:0] expQ[$];
  string      tagQ[$];
  bit         done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  updn_counter dut_i (
    .clk    (clk),
    .rst    (rst),
    .upEn   (upEn),
    .downEn (downEn),
    .count  (count),
    .fault  (fault)
  );

  // monitor: compare count shortly after each edge
  always @(posedge clk) begin
    #1;
    if (expQ.size() > 0) begin
      logic [2:0] e;
      string t;
      e = expQ.pop_front();
      t = tagQ.pop_front();
      checks++;
      if (count !== e) begin
        fails++;
        $display("FAIL %s count actual=%b expected=%b", t, count, e);
      end
    end
  end

  task automatic step(input logic r, input logic u, input logic d, input string tag);
    @(negedge clk);
    rst = r; upEn = u; downEn = d;
    #1;
    checks++;
    if (fault !== (u & d)) begin
      fails++;
      $display("FAIL %s fault actual=%b expected=%b", (u & d) ? "R5" : "R8", fault, u & d);
    end
    if (r)            model = 3'b000;
    else if (u && !d) model = model + 3'd1;
    else if (d && !u) model = model - 3'd1;
    expQ.push_back(model);
    tagQ.push_back(tag);
  endtask

  initial begin
    #(CLK_PERIOD * 2000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    step(1, 0, 0, "R1");
    step(1, 1, 1, "R1");
    step(0, 0, 0, "R4");
    step(0, 0, 0, "R4");
    for (int i = 0; i < 7; i++) step(0, 1, 0, "R2");
    step(0, 1, 1, "R5");               // hold at 111
    step(0, 1, 0, "R6");               // 111 -> 000
    step(0, 1, 1, "R5");               // hold at 000 after wrap
    step(0, 0, 1, "R7");               // 000 -> 111
    for (int i = 0; i < 8; i++) step(0, 0, 1, "R3");
    step(0, 0, 0, "R4");
    step(0, 1, 0, "R2");
    step(0, 0, 1, "R3");
    step(0, 1, 1, "R5");
    step(0, 1, 0, "R2");
    step(0, 1, 0, "R2");
    step(1, 1, 0, "R1");               // reset wins over live enable
    step(0, 0, 1, "R7");
    step(0, 0, 0, "R4");
    @(negedge clk);
    upEn = 0; downEn = 0;
    @(negedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule